// File: doc/BRIEF.md
# Control Transfer Event Classifier

This block sits beside the retirement stage of a processor core and watches one retired instruction per cycle. When the retiring instruction is a control transfer, it works out what kind of transfer it was: conditional branch, direct or indirect call, jump with or without a link register, co-routine swap, function return or trap return. It does this from a pre-decoded opcode class and the destination and source register indices, using the two conventional link registers, x1 and x5. It then raises one increment strobe for each event the instruction belongs to. These include the union events built from the base types: all taken transfers, predicted transfers, all jumps, all calls, all returns, all calls including swaps, unconditional transfers, and any transfer.

Two strobe vectors leave the block. One covers every qualifying retirement. The other covers only those whose mispredict flag was set. Each strobe drives a wrapping counter in an internal bank. Counting is gated by a per-privilege-mode enable mask. Trap returns are judged by the mode they were executed from, and every other transfer by the current mode. A synchronous clear input zeroes every counter at once.

Top module: `ctxev_tally`

## Requirements
- R1: Strobes are registered. A retirement with `ret_valid` high, sampled at a clock edge, raises its strobes for exactly the following cycle. A retirement with `ret_valid` low, or with a `ret_kind` code that is not a transfer (0, 13, 14, 15), raises no strobe. Kind codes are: 1 conditional branch, 2 JAL, 3 JALR, 4 compressed jump, 5 compressed jump-and-link, 6 compressed register jump, 7 compressed register jump-and-link, 8 table jump, 9 table jump with link, 10 pop-and-return, 11 MRET, 12 SRET.
- R2: A JALR is classified as follows, where a link register is x1 or x5. It is a co-routine swap when rd and rs1 are both link registers and differ. Otherwise it is an indirect call when rd is a link register. Otherwise it is a return when rs1 is a link register. Otherwise it is an indirect jump when rd is x0. Otherwise it is an other indirect linked jump. Strobe bits: 3 indirect, 4 indirect call, 5 indirect jump, 6 other indirect linked jump, 11 co-routine swap, 12 return.
- R3: The compressed register jump-and-link (link in x1) is a co-routine swap when rs1 is x5 and an indirect call otherwise. The compressed register jump is a return when rs1 is a link register and an indirect jump otherwise.
- R4: A JAL is a direct call when rd is a link register, a direct jump when rd is x0, and an other direct linked jump otherwise. The compressed jump-and-link and the table jump with link are direct calls. The compressed jump and the plain table jump are direct jumps. Strobe bits: 7 direct, 8 direct call, 9 direct jump, 10 other direct linked jump.
- R5: A conditional branch raises bit 0, plus bit 1 when `ret_taken` is high or bit 2 when it is low. A pop-and-return raises the return bit 12.
- R6: MRET and SRET raise bit 13 only when `mode_en[ret_src_priv]` is set. Every other transfer counts only when `mode_en[ret_priv]` is set. So with only bit 0 (user mode) set, trap returns executed from a higher mode never count.
- R7: Union bits are: 14 taken (all non-branch transfers plus taken branches), 15 predicted (branch, indirect, swap, return), 16 jump (direct and indirect jumps, with or without link, excluding calls and returns), 17 call (direct and indirect calls), 18 all returns (return or swap), 19 all calls (call or swap), 20 unconditional (every non-branch transfer), 21 any transfer.
- R8: `mis_inc` equals `all_inc` restricted to retirements with `ret_mispred` high. Bits 7, 8, 9, 10 and 15 of `mis_inc` are never set.
- R9: Every counter adds one for each cycle its strobe is high, keeps its value otherwise, and wraps to zero after its maximum of `CNT_W` bits.
- R10: `cnt_clear` high at an edge sets every counter to zero at that edge, overriding a coincident increment. It does not affect the strobes.
- R11: While `rst_n` is low at a clock edge, all strobes and counters become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_valid | input | 1 | A retirement is presented this cycle |
| ret_kind | input | 4 | Opcode class code (see R1) |
| ret_rd | input | REG_W | Destination register index |
| ret_rs1 | input | REG_W | First source register index |
| ret_taken | input | 1 | Conditional branch was taken |
| ret_mispred | input | 1 | Transfer was mispredicted |
| ret_priv | input | PRIV_W | Privilege mode at retirement |
| ret_src_priv | input | PRIV_W | Mode a trap return was executed from |
| mode_en | input | 2**PRIV_W | Per-mode counting enable |
| cnt_clear | input | 1 | Synchronous clear of all counters |
| all_inc | output | 22 | Increment strobes, all retirements |
| mis_inc | output | 22 | Increment strobes, mispredicted retirements |
| all_cnt | output | 22*CNT_W | Counters for all retirements, event e at bits [e*CNT_W +: CNT_W] |
| mis_cnt | output | 22*CNT_W | Counters for mispredicted retirements, same layout |

## Verification
The bench sweeps JALR over every pairing of rd and rs1 drawn from x0, x1, x5 and a plain register. This is where the swap-before-call-before-return priority matters. A decoder that tested rd alone would report JALR x1,x5 as a call, and one that ignored the rs1 order would call JALR x1,x1 a swap. It runs trap returns under a user-only mask with a higher originating mode, which a design gating on the current mode would wrongly count. It raises clear in the same cycle as a strobe, where a design that let the increment win would leave a count of one. It also runs a narrow counter past its maximum, where a saturating or sticky counter would show a value other than the wrapped one. Long random streams with mixed privilege masks and mispredicts are compared cycle by cycle against an independent model. That catches direct or predicted events leaking into the mispredict vector.

// File: rtl/ctxev_pkg.sv
// Shared definitions for the control transfer event classifier.
// Holds the opcode class codes, the strobe bit positions and the
// classification record passed from decode to the strobe stage.
package ctxev_pkg;

    // Opcode classes presented at retirement (pre-decoded upstream).
    localparam logic [3:0] K_BRANCH = 4'd1;
    localparam logic [3:0] K_JAL    = 4'd2;
    localparam logic [3:0] K_JALR   = 4'd3;
    localparam logic [3:0] K_CJ     = 4'd4;
    localparam logic [3:0] K_CJAL   = 4'd5;
    localparam logic [3:0] K_CJR    = 4'd6;
    localparam logic [3:0] K_CJALR  = 4'd7;
    localparam logic [3:0] K_TBLJ   = 4'd8;
    localparam logic [3:0] K_TBLJAL = 4'd9;
    localparam logic [3:0] K_POPRET = 4'd10;
    localparam logic [3:0] K_MRET   = 4'd11;
    localparam logic [3:0] K_SRET   = 4'd12;

    // Strobe bit positions.
    localparam int EV_BRANCH   = 0;
    localparam int EV_BR_TK    = 1;
    localparam int EV_BR_NT    = 2;
    localparam int EV_IND      = 3;
    localparam int EV_IND_CALL = 4;
    localparam int EV_IND_JMP  = 5;
    localparam int EV_IND_LJMP = 6;
    localparam int EV_DIR      = 7;
    localparam int EV_DIR_CALL = 8;
    localparam int EV_DIR_JMP  = 9;
    localparam int EV_DIR_LJMP = 10;
    localparam int EV_SWAP     = 11;
    localparam int EV_FRET     = 12;
    localparam int EV_TRAPRET  = 13;
    localparam int EV_TAKEN    = 14;
    localparam int EV_PRED     = 15;
    localparam int EV_JUMP     = 16;
    localparam int EV_CALL     = 17;
    localparam int EV_RETALL   = 18;
    localparam int EV_CALLALL  = 19;
    localparam int EV_UNCOND   = 20;
    localparam int EV_ANY      = 21;
    localparam int EV_COUNT    = 22;

    // Events that exist for mispredict counting (direct and predicted excluded).
    localparam logic [EV_COUNT-1:0] MIS_MASK =
        ~((EV_COUNT'(1) << EV_DIR) | (EV_COUNT'(1) << EV_DIR_CALL) |
          (EV_COUNT'(1) << EV_DIR_JMP) | (EV_COUNT'(1) << EV_DIR_LJMP) |
          (EV_COUNT'(1) << EV_PRED));

    // Mutually exclusive base classification of one retirement.
    typedef struct packed {
        logic br;
        logic br_tk;
        logic br_nt;
        logic ind_call;
        logic ind_jmp;
        logic ind_ljmp;
        logic dir_call;
        logic dir_jmp;
        logic dir_ljmp;
        logic swap;
        logic fret;
        logic trapret;
    } xfer_base_t;

endpackage

// File: rtl/ctxev_decode.sv
// Combinational classifier: maps one retirement (opcode class plus rd/rs1)
// to at most one base transfer type using the x1/x5 link-register rules.
// Assumes the opcode class was decoded upstream; unknown codes classify as none.
module ctxev_decode
    import ctxev_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             valid,
    input  logic [3:0]       kind,
    input  logic [REG_W-1:0] rd,
    input  logic [REG_W-1:0] rs1,
    input  logic             taken,
    output xfer_base_t       base,
    output logic             is_trap
);

    localparam logic [REG_W-1:0] RA = REG_W'(1);
    localparam logic [REG_W-1:0] T0 = REG_W'(5);
    localparam logic [REG_W-1:0] X0 = REG_W'(0);

    logic rd_link;
    logic rs_link;

    // Link-register tests shared by every register-based form.
    always_comb begin
        rd_link = (rd == RA) || (rd == T0);
        rs_link = (rs1 == RA) || (rs1 == T0);
    end

    // Pick the single base type for this retirement.
    always_comb begin
        base    = '0;
        is_trap = 1'b0;
        if (valid) begin
            case (kind)
                K_BRANCH: begin
                    base.br    = 1'b1;
                    base.br_tk = taken;
                    base.br_nt = !taken;
                end
                K_JAL: begin
                    if (rd_link)        base.dir_call = 1'b1;
                    else if (rd == X0)  base.dir_jmp  = 1'b1;
                    else                base.dir_ljmp = 1'b1;
                end
                K_JALR: begin
                    if (rd_link && rs_link && (rd != rs1)) base.swap     = 1'b1;
                    else if (rd_link)                      base.ind_call = 1'b1;
                    else if (rs_link)                      base.fret     = 1'b1;
                    else if (rd == X0)                     base.ind_jmp  = 1'b1;
                    else                                   base.ind_ljmp = 1'b1;
                end
                K_CJ, K_TBLJ:     base.dir_jmp  = 1'b1;
                K_CJAL, K_TBLJAL: base.dir_call = 1'b1;
                K_CJR: begin
                    if (rs_link) base.fret    = 1'b1;
                    else         base.ind_jmp = 1'b1;
                end
                K_CJALR: begin
                    if (rs1 == T0) base.swap     = 1'b1;
                    else           base.ind_call = 1'b1;
                end
                K_POPRET: base.fret = 1'b1;
                K_MRET, K_SRET: begin
                    base.trapret = 1'b1;
                    is_trap      = 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ctxev_strobe.sv
// Strobe stage: applies privilege-mode gating, expands the base type into
// base plus union events, and registers the all-retirement and mispredict
// strobe vectors. Assumes at most one retirement per cycle.
module ctxev_strobe
    import ctxev_pkg::*;
#(
    parameter int PRIV_W = 2,
    localparam int MODES = 1 << PRIV_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid,
    input  xfer_base_t          base,
    input  logic                is_trap,
    input  logic                mispred,
    input  logic [PRIV_W-1:0]   priv,
    input  logic [PRIV_W-1:0]   src_priv,
    input  logic [MODES-1:0]    mode_en,
    output logic [EV_COUNT-1:0] all_inc,
    output logic [EV_COUNT-1:0] mis_inc
);

    logic [EV_COUNT-1:0] ev;
    logic                count_ok;
    logic                uncond;
    logic                ind_any;
    logic                call_any;

    // Trap returns are judged by the mode they left; all else by the current mode.
    always_comb count_ok = mode_en[is_trap ? src_priv : priv];

    // Expand the base type into the full event vector.
    always_comb begin
        ind_any  = base.ind_call | base.ind_jmp | base.ind_ljmp;
        call_any = base.ind_call | base.dir_call;
        uncond   = ind_any | base.dir_call | base.dir_jmp | base.dir_ljmp |
                   base.swap | base.fret | base.trapret;
        ev              = '0;
        ev[EV_BRANCH]   = base.br;
        ev[EV_BR_TK]    = base.br_tk;
        ev[EV_BR_NT]    = base.br_nt;
        ev[EV_IND]      = ind_any;
        ev[EV_IND_CALL] = base.ind_call;
        ev[EV_IND_JMP]  = base.ind_jmp;
        ev[EV_IND_LJMP] = base.ind_ljmp;
        ev[EV_DIR]      = base.dir_call | base.dir_jmp | base.dir_ljmp;
        ev[EV_DIR_CALL] = base.dir_call;
        ev[EV_DIR_JMP]  = base.dir_jmp;
        ev[EV_DIR_LJMP] = base.dir_ljmp;
        ev[EV_SWAP]     = base.swap;
        ev[EV_FRET]     = base.fret;
        ev[EV_TRAPRET]  = base.trapret;
        ev[EV_TAKEN]    = uncond | base.br_tk;
        ev[EV_PRED]     = base.br | ind_any | base.swap | base.fret;
        ev[EV_JUMP]     = base.ind_jmp | base.ind_ljmp | base.dir_jmp | base.dir_ljmp;
        ev[EV_CALL]     = call_any;
        ev[EV_RETALL]   = base.fret | base.swap;
        ev[EV_CALLALL]  = call_any | base.swap;
        ev[EV_UNCOND]   = uncond;
        ev[EV_ANY]      = uncond | base.br;
    end

    // Register both strobe vectors; each bit lasts one cycle per retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            all_inc <= '0;
            mis_inc <= '0;
        end else begin
            all_inc <= count_ok ? ev : '0;
            mis_inc <= (count_ok && mispred) ? (ev & MIS_MASK) : '0;
        end
    end

    // R1: any strobe traces back to a valid retirement one cycle earlier.
    p_strobe_from_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|all_inc) |-> $past(valid));

    // R2: base types are mutually exclusive.
    p_base_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({all_inc[EV_BRANCH], all_inc[EV_IND_CALL], all_inc[EV_IND_JMP],
                  all_inc[EV_IND_LJMP], all_inc[EV_DIR_CALL], all_inc[EV_DIR_JMP],
                  all_inc[EV_DIR_LJMP], all_inc[EV_SWAP], all_inc[EV_FRET],
                  all_inc[EV_TRAPRET]}));

    // R5: a taken branch is a branch and not a not-taken branch.
    p_taken_branch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        all_inc[EV_BR_TK] |-> (all_inc[EV_BRANCH] && !all_inc[EV_BR_NT]));

    // R7: all-returns covers both returns and swaps.
    p_retall_union_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (all_inc[EV_FRET] || all_inc[EV_SWAP]) |-> all_inc[EV_RETALL]);

    // R8: mispredict strobes are a subset of the all-retirement strobes.
    p_mis_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mis_inc & ~all_inc) == '0);

    // R8: no direct or predicted event in the mispredict vector.
    p_mis_no_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mis_inc[EV_DIR] || mis_inc[EV_DIR_CALL] || mis_inc[EV_DIR_JMP] ||
          mis_inc[EV_DIR_LJMP] || mis_inc[EV_PRED]));

endmodule

// File: rtl/ctxev_counter.sv
// One event counter: increments on its strobe, wraps at its width, and
// clears synchronously with clear taking priority over an increment.
module ctxev_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);

    // Count update with clear over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (inc) q <= q + W'(1);
    end

    // R10: a clear leaves the counter at zero.
    p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clr)) |-> (q == '0));

    // R9: one strobe adds exactly one, wrapping at the width.
    p_inc_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr) && $past(inc)) |-> (q == $past(q) + W'(1)));

    // R9: without strobe or clear the count holds.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr) && !$past(inc)) |-> $stable(q));

endmodule

// File: rtl/ctxev_tally.sv
// Top of the control transfer event classifier: decode, strobe stage and a
// bank of wrapping counters, one per event for all retirements and one per
// mispredict-capable event. Assumes one retirement per cycle.
module ctxev_tally
    import ctxev_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int REG_W  = 5,
    parameter int PRIV_W = 2,
    localparam int MODES = 1 << PRIV_W,
    localparam int BUS_W = EV_COUNT * CNT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ret_valid,
    input  logic [3:0]          ret_kind,
    input  logic [REG_W-1:0]    ret_rd,
    input  logic [REG_W-1:0]    ret_rs1,
    input  logic                ret_taken,
    input  logic                ret_mispred,
    input  logic [PRIV_W-1:0]   ret_priv,
    input  logic [PRIV_W-1:0]   ret_src_priv,
    input  logic [MODES-1:0]    mode_en,
    input  logic                cnt_clear,
    output logic [EV_COUNT-1:0] all_inc,
    output logic [EV_COUNT-1:0] mis_inc,
    output logic [BUS_W-1:0]    all_cnt,
    output logic [BUS_W-1:0]    mis_cnt
);

    xfer_base_t base;
    logic       is_trap;

    ctxev_decode #(.REG_W(REG_W)) u_decode (
        .valid   (ret_valid),
        .kind    (ret_kind),
        .rd      (ret_rd),
        .rs1     (ret_rs1),
        .taken   (ret_taken),
        .base    (base),
        .is_trap (is_trap)
    );

    ctxev_strobe #(.PRIV_W(PRIV_W)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (ret_valid),
        .base     (base),
        .is_trap  (is_trap),
        .mispred  (ret_mispred),
        .priv     (ret_priv),
        .src_priv (ret_src_priv),
        .mode_en  (mode_en),
        .all_inc  (all_inc),
        .mis_inc  (mis_inc)
    );

    for (genvar e = 0; e < EV_COUNT; e++) begin : g_ev
        ctxev_counter #(.W(CNT_W)) u_all (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clear),
            .inc   (all_inc[e]),
            .q     (all_cnt[e*CNT_W +: CNT_W])
        );
        if (MIS_MASK[e]) begin : g_mis
            ctxev_counter #(.W(CNT_W)) u_mis (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (cnt_clear),
                .inc   (mis_inc[e]),
                .q     (mis_cnt[e*CNT_W +: CNT_W])
            );
        end else begin : g_nomis
            assign mis_cnt[e*CNT_W +: CNT_W] = '0;
        end
    end

endmodule

// File: tb/ctxev_tally_tb.sv
`timescale 1ns/1ps
module ctxev_tally_tb;

    localparam int CW  = 6;
    localparam int NE  = 22;
    localparam logic [63:0] CMASK = (64'd1 << CW) - 64'd1;

    logic clk = 1'b0;
    logic rst_n;
    logic ret_valid;
    logic [3:0] ret_kind;
    logic [4:0] ret_rd, ret_rs1;
    logic ret_taken, ret_mispred;
    logic [1:0] ret_priv, ret_src_priv;
    logic [3:0] mode_en;
    logic cnt_clear;
    logic [NE-1:0] all_inc, mis_inc;
    logic [NE*CW-1:0] all_cnt, mis_cnt;

    int checks = 0;
    int errs   = 0;

    // reference state
    logic [NE-1:0] m_all, m_mis;
    logic [63:0]   m_acnt [NE];
    logic [63:0]   m_mcnt [NE];
    logic          last_clear;

    always #4 clk = ~clk;

    ctxev_tally #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_kind(ret_kind),
        .ret_rd(ret_rd), .ret_rs1(ret_rs1), .ret_taken(ret_taken),
        .ret_mispred(ret_mispred), .ret_priv(ret_priv), .ret_src_priv(ret_src_priv),
        .mode_en(mode_en), .cnt_clear(cnt_clear), .all_inc(all_inc),
        .mis_inc(mis_inc), .all_cnt(all_cnt), .mis_cnt(mis_cnt)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit lnk(input logic [4:0] r);
        return r == 5'd1 || r == 5'd5;
    endfunction

    // Behavioural classification: returns names of hits as bit positions.
    function automatic logic [NE-1:0] model_ev(input logic v, input logic [3:0] k,
            input logic [4:0] rd, input logic [4:0] rs, input logic tk);
        logic [NE-1:0] r = '0;
        int t = -1; // base type index
        if (!v) return r;
        case (k)
            4'd1: t = 0;
            4'd2: t = lnk(rd) ? 8 : (rd == 0 ? 9 : 10);
            4'd3: begin
                if (lnk(rd) && lnk(rs) && rd != rs) t = 11;
                else if (lnk(rd)) t = 4;
                else if (lnk(rs)) t = 12;
                else if (rd == 0) t = 5;
                else t = 6;
            end
            4'd4, 4'd8: t = 9;
            4'd5, 4'd9: t = 8;
            4'd6: t = lnk(rs) ? 12 : 5;
            4'd7: t = (rs == 5) ? 11 : 4;
            4'd10: t = 12;
            4'd11, 4'd12: t = 13;
            default: t = -1;
        endcase
        if (t < 0) return r;
        r[t] = 1'b1;
        if (t == 0) begin
            r[tk ? 1 : 2] = 1'b1;
            r[15] = 1'b1;
            if (tk) r[14] = 1'b1;
        end else begin
            r[14] = 1'b1; r[20] = 1'b1;
        end
        r[21] = 1'b1;
        if (t >= 4 && t <= 6) begin r[3] = 1'b1; r[15] = 1'b1; end
        if (t >= 8 && t <= 10) r[7] = 1'b1;
        if (t == 11 || t == 12) begin r[15] = 1'b1; r[18] = 1'b1; end
        if (t == 5 || t == 6 || t == 9 || t == 10) r[16] = 1'b1;
        if (t == 4 || t == 8) begin r[17] = 1'b1; r[19] = 1'b1; end
        if (t == 11) r[19] = 1'b1;
        return r;
    endfunction

    function automatic string tag_of(input int i);
        if (i <= 2) return "R5";
        if (i >= 7 && i <= 10) return "R4";
        if (i == 13) return "R6";
        if (i >= 14) return "R7";
        return "R2";
    endfunction

    // One clock: update reference after the edge, then compare away from it.
    task automatic tick();
        logic [NE-1:0] ev;
        logic [NE-1:0] mm;
        logic en;
        @(posedge clk);
        if (!rst_n) begin
            m_all = '0; m_mis = '0;
            for (int i = 0; i < NE; i++) begin m_acnt[i] = 0; m_mcnt[i] = 0; end
        end else begin
            for (int i = 0; i < NE; i++) begin
                if (cnt_clear) begin m_acnt[i] = 0; m_mcnt[i] = 0; end
                else begin
                    if (m_all[i]) m_acnt[i] = (m_acnt[i] + 1) & CMASK;
                    if (m_mis[i]) m_mcnt[i] = (m_mcnt[i] + 1) & CMASK;
                end
            end
            ev = model_ev(ret_valid, ret_kind, ret_rd, ret_rs1, ret_taken);
            en = (ret_kind == 4'd11 || ret_kind == 4'd12) ? mode_en[ret_src_priv]
                                                          : mode_en[ret_priv];
            mm = '1;
            mm[7] = 0; mm[8] = 0; mm[9] = 0; mm[10] = 0; mm[15] = 0;
            m_all = en ? ev : '0;
            m_mis = (en && ret_mispred) ? (ev & mm) : '0;
        end
        last_clear = cnt_clear;
        #2;
        for (int i = 0; i < NE; i++) begin
            chk((m_all == '0) ? "R1" : tag_of(i), 64'(all_inc[i]), 64'(m_all[i]));
            chk("R8", 64'(mis_inc[i]), 64'(m_mis[i]));
            chk(last_clear ? "R10" : "R9", 64'(all_cnt[i*CW +: CW]), m_acnt[i]);
            chk(last_clear ? "R10" : "R9", 64'(mis_cnt[i*CW +: CW]), m_mcnt[i]);
        end
    endtask

    task automatic drive(input logic v, input logic [3:0] k, input logic [4:0] rd,
                         input logic [4:0] rs, input logic tk, input logic mp);
        ret_valid = v; ret_kind = k; ret_rd = rd; ret_rs1 = rs;
        ret_taken = tk; ret_mispred = mp;
    endtask

    function automatic logic [4:0] pick_reg();
        case ($urandom_range(0, 3))
            0: return 5'd0;
            1: return 5'd1;
            2: return 5'd5;
            default: return 5'($urandom_range(2, 31));
        endcase
    endfunction

    initial begin
        logic [4:0] regs [4];
        regs[0] = 5'd0; regs[1] = 5'd1; regs[2] = 5'd5; regs[3] = 5'd9;
        rst_n = 1'b0; cnt_clear = 1'b0; mode_en = 4'b1111;
        ret_priv = 2'd3; ret_src_priv = 2'd3;
        drive(1'b1, 4'd3, 5'd1, 5'd5, 1'b0, 1'b1);
        tick(); tick();
        // R11: reset state
        chk("R11", 64'(all_inc), 64'd0);
        chk("R11", 64'(all_cnt[CW-1:0]), 64'd0);
        rst_n = 1'b1;
        drive(1'b0, 4'd0, 5'd0, 5'd0, 1'b0, 1'b0);
        tick();

        // R2: JALR link-register rule sweep
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
                drive(1'b1, 4'd3, regs[a], regs[b], 1'b0, (a + b) % 2 == 1);
                tick();
            end
        drive(1'b1, 4'd3, 5'd1, 5'd5, 1'b0, 1'b0); tick();
        chk("R2 swap x1,x5", 64'(all_inc[11]), 64'd1);
        drive(1'b1, 4'd3, 5'd1, 5'd1, 1'b0, 1'b0); tick();
        chk("R2 call x1,x1", 64'(all_inc[4]), 64'd1);

        // R3: compressed register forms
        for (int b = 0; b < 4; b++) begin
            drive(1'b1, 4'd7, 5'd1, regs[b], 1'b0, 1'b1); tick();
            drive(1'b1, 4'd6, 5'd0, regs[b], 1'b0, 1'b0); tick();
        end
        drive(1'b1, 4'd7, 5'd1, 5'd5, 1'b0, 1'b0); tick();
        chk("R3 c.jalr x5 swap", 64'(all_inc[11]), 64'd1);
        drive(1'b1, 4'd6, 5'd0, 5'd5, 1'b0, 1'b0); tick();
        chk("R3 c.jr x5 return", 64'(all_inc[12]), 64'd1);

        // R4 / R5: direct forms, branches, pop-return
        for (int k = 1; k <= 12; k++)
            for (int a = 0; a < 4; a++) begin
                drive(1'b1, 4'(k), regs[a], regs[3 - a], a[0], 1'b1); tick();
            end

        // R1: invalid and non-transfer codes, strobe single cycle
        drive(1'b1, 4'd14, 5'd1, 5'd5, 1'b1, 1'b1); tick();
        chk("R1 non-transfer", 64'(all_inc), 64'd0);
        drive(1'b0, 4'd2, 5'd1, 5'd0, 1'b0, 1'b0); tick();
        chk("R1 valid low", 64'(all_inc), 64'd0);
        drive(1'b1, 4'd2, 5'd1, 5'd0, 1'b0, 1'b0); tick();
        drive(1'b0, 4'd0, 5'd0, 5'd0, 1'b0, 1'b0); tick();
        chk("R1 one cycle", 64'(all_inc), 64'd0);

        // R6: user-only mask, trap return from machine mode
        mode_en = 4'b0001; ret_priv = 2'd0; ret_src_priv = 2'd3;
        drive(1'b1, 4'd11, 5'd0, 5'd0, 1'b0, 1'b0); tick();
        chk("R6 mret under user mask", 64'(all_inc[13]), 64'd0);
        mode_en = 4'b0010; ret_src_priv = 2'd1;
        drive(1'b1, 4'd12, 5'd0, 5'd0, 1'b0, 1'b0); tick();
        chk("R6 sret from enabled S", 64'(all_inc[13]), 64'd1);
        drive(1'b1, 4'd2, 5'd1, 5'd0, 1'b0, 1'b0); tick();
        chk("R6 jal in disabled U", 64'(all_inc[21]), 64'd0);
        mode_en = 4'b1111; ret_priv = 2'd3; ret_src_priv = 2'd3;

        // R10: clear coincident with a strobe
        drive(1'b1, 4'd2, 5'd1, 5'd0, 1'b0, 1'b0); tick();
        cnt_clear = 1'b1; drive(1'b1, 4'd2, 5'd1, 5'd0, 1'b0, 1'b0); tick();
        chk("R10 clear wins", 64'(all_cnt[8*CW +: CW]), 64'd0);
        cnt_clear = 1'b0;

        // R9: wrap of a narrow counter
        cnt_clear = 1'b1; drive(1'b0, 4'd0, 5'd0, 5'd0, 1'b0, 1'b0); tick();
        cnt_clear = 1'b0;
        for (int n = 0; n < 70; n++) begin
            drive(1'b1, 4'd5, 5'd1, 5'd0, 1'b0, 1'b0); tick();
        end
        drive(1'b0, 4'd0, 5'd0, 5'd0, 1'b0, 1'b0); tick();
        chk("R9 wrap", 64'(all_cnt[8*CW +: CW]), 64'd6);

        // Random streams
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 49) == 0) mode_en = 4'($urandom_range(0, 15));
            ret_priv = 2'($urandom_range(0, 3));
            ret_src_priv = 2'($urandom_range(0, 3));
            cnt_clear = ($urandom_range(0, 99) == 0);
            drive($urandom_range(0, 4) != 0, 4'($urandom_range(0, 15)), pick_reg(),
                  pick_reg(), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            tick();
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        errs++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule